// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block runs a single command transaction between a host and a management co-processor through a memory-mapped mailbox. A requester gives a command word, a direction flag and four 32-bit arguments through a valid/ready handshake. The sequencer then drives a one-access-at-a-time register master port. It waits for the co-processor to go idle, clears the status word, writes the arguments when the command sends data, writes the command word and rings a doorbell in a separate interrupt-controller space. It then waits for a rising edge on the completion interrupt line.

Once completion arrives, or the wait runs out, the sequencer reads the status word and checks that it is in range. For a receive command it reads the four argument words back. It releases the mailbox by clearing the status word and reports a compact result code together with any returned arguments, using a one-cycle done pulse. Only one transaction runs at a time. The requester sees ready low from the moment a request is taken until the cycle after done.

Top module: `mbox_cmd_seq`

## Requirements
- R1: Before issuing, the command word (space 0, offset 0x00) is read repeatedly until it reads zero. If POLL_LIMIT reads in a row are non-zero, the transaction ends with result code 1 (retry) and no write takes place.
- R2: The first write of a transaction that passed the poll puts 0x0000_0000 into the status word (space 0, offset 0x04). This write comes before any argument or command write.
- R3: For a send command (req_send=1), arguments 0..3 (argument i in bits 32i+31:32i of req_args) are written in order to offsets 0x18, 0x1C, 0x20 and 0x24, and then req_cmd is written to offset 0x00. A receive command writes no argument words.
- R4: Directly after the command write, the sequencer writes 0x8000_0000 to offset 0x04 of the interrupt space (bus_space=1). This is the only write it ever makes to that space.
- R5: Only a rising edge on irq that comes after the command write counts as completion. Edges that arrive earlier in the transaction are discarded.
- R6: If no qualifying edge arrives within PRESCALE*TIMEOUT_TICKS cycles of waiting, the status word is still read and the result is code 2 (timeout).
- R7: A status value of 0 or above 0xFF gives code 2 (timeout). In that case neither the argument read-back nor the closing status clear takes place.
- R8: For a receive command with a valid status, the four words at 0x18..0x24 are returned on rsp_args in the same bit order as req_args, and the status word is then cleared to zero. For send commands and failed transactions, rsp_args is zero.
- R9: A valid status maps to result codes as follows: 0xF1 gives 3 (invalid), 0xF2 gives 4 (unsupported), 0xF3 gives 5 (no map), 0xF4 gives 6 (map already set) and 0xFF gives 7 (I/O failure). 0xF0 and every other in-range value give 0 (success).
- R10: req_ready is high only while idle. A request is taken when req_valid and req_ready are both high. done is a one-cycle pulse, and req_ready goes high again in the following cycle.
- R11: After reset, req_ready is 1, done is 0 and bus_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_cmd | input | 32 | Command word to issue |
| req_send | input | 1 | 1: write arguments before the command; 0: read them back after |
| req_args | input | 128 | Four argument words, argument 0 in the low 32 bits |
| done | output | 1 | One-cycle completion pulse |
| rsp_code | output | 3 | Result code (0 ok, 1 retry, 2 timeout, 3..7 firmware errors) |
| rsp_args | output | 128 | Returned argument words, same order as req_args |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_space | output | 1 | 0 mailbox space, 1 interrupt-controller space |
| bus_addr | output | 8 | Byte offset inside the selected space |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completes in this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| irq | input | 1 | Completion interrupt from the co-processor |

## Verification
Send and receive commands are run against a behavioural co-processor. The bench compares each result and the exact write trace, which separates the two directions and shows where the closing clear is skipped. The status byte is swept through every mapped error value, through an unmapped in-range value, and through 0 and 0x100, which tells the error mapping apart from the range check. The idle poll is tried with 9999 and then 10000 busy reads, which pins down the retry boundary. A spurious interrupt is raised during polling, once with a real completion following it and once with none, to show that stale edges are thrown away. A silent co-processor exercises the timeout counter.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DW   = 32;
    localparam int AW   = 8;
    localparam int NARG = 4;
    localparam int IW   = $clog2(NARG);

    localparam logic [AW-1:0] OFS_CMD      = 8'h00;
    localparam logic [AW-1:0] OFS_STAT     = 8'h04;
    localparam logic [AW-1:0] OFS_PARAM0   = 8'h18;
    localparam logic [AW-1:0] OFS_DOORBELL = 8'h04;
    localparam logic [DW-1:0] DOORBELL_VAL = 32'h8000_0000;
    localparam logic [DW-1:0] STAT_TOP     = 32'h0000_00FF;

    localparam logic SP_MBOX = 1'b0;
    localparam logic SP_INTC = 1'b1;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_RETRY   = 3'd1,
        RES_TIMEOUT = 3'd2,
        RES_INVALID = 3'd3,
        RES_NOSUPP  = 3'd4,
        RES_NOMAP   = 3'd5,
        RES_MAPSET  = 3'd6,
        RES_IOFAIL  = 3'd7
    } res_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL,
        ST_CLR_PRE,
        ST_ARG_WR,
        ST_CMD_WR,
        ST_RING,
        ST_WAIT,
        ST_STAT_RD,
        ST_ARG_RD,
        ST_CLR_POST,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic          req;
        logic          we;
        logic          space;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_op_t;

    function automatic res_e map_status(input logic [7:0] s);
        res_e r;
        case (s)
            8'hF1:   r = RES_INVALID;
            8'hF2:   r = RES_NOSUPP;
            8'hF3:   r = RES_NOMAP;
            8'hF4:   r = RES_MAPSET;
            8'hFF:   r = RES_IOFAIL;
            default: r = RES_OK;
        endcase
        return r;
    endfunction

    function automatic logic [AW-1:0] param_addr(input logic [IW-1:0] idx);
        return OFS_PARAM0 + AW'({idx, 2'b00});
    endfunction

    function automatic logic status_bad(input logic [DW-1:0] s);
        return (s == '0) || (s > STAT_TOP);
    endfunction

endpackage

// File: rtl/mbx_irq_catch.sv
module mbx_irq_catch (
    input  logic clk,
    input  logic rst,
    input  logic irq,
    input  logic clr,
    output logic pending
);
    logic irq_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_prev <= 1'b0;
            pending  <= 1'b0;
        end else begin
            irq_prev <= irq;
            if (clr)
                pending <= 1'b0;
            else if (irq && !irq_prev)
                pending <= 1'b1;
        end
    end

    AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (rst) clr |=> !pending); // R5
    AST_EDGE_CAUGHT: assert property (@(posedge clk) disable iff (rst) (irq && !irq_prev && !clr) |=> pending); // R5

endmodule

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
    parameter int PRESCALE      = 1000,
    parameter int TIMEOUT_TICKS = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;

    logic [PW-1:0] pre;
    logic [TW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre     <= '0;
            ticks   <= '0;
            expired <= 1'b0;
        end else if (!expired) begin
            if (pre == PW'(PRESCALE - 1)) begin
                pre <= '0;
                if (ticks == TW'(TIMEOUT_TICKS - 1))
                    expired <= 1'b1;
                else
                    ticks <= ticks + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst) !run |=> !expired); // R6
    AST_EXPIRY_HOLDS: assert property (@(posedge clk) disable iff (rst) (run && expired) |=> (expired || !run)); // R6

endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
    import mbx_pkg::*;
#(
    parameter int POLL_LIMIT    = 10000,
    parameter int PRESCALE      = 1000,
    parameter int TIMEOUT_TICKS = 300
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [DW-1:0]        req_cmd,
    input  logic                 req_send,
    input  logic [NARG*DW-1:0]   req_args,
    output logic                 done,
    output logic [2:0]           rsp_code,
    output logic [NARG*DW-1:0]   rsp_args,
    output logic                 bus_req,
    output logic                 bus_we,
    output logic                 bus_space,
    output logic [AW-1:0]        bus_addr,
    output logic [DW-1:0]        bus_wdata,
    input  logic                 bus_ack,
    input  logic [DW-1:0]        bus_rdata,
    input  logic                 irq
);
    localparam int PCW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [IW-1:0] LAST_ARG = IW'(NARG - 1);

    seq_state_e                 state;
    logic [PCW-1:0]             poll_cnt;
    logic [IW-1:0]              idx;
    logic [DW-1:0]              cmd_q;
    logic                       send_q;
    logic [NARG-1:0][DW-1:0]    args_q;
    logic [NARG-1:0][DW-1:0]    rd_q;
    logic [7:0]                 stat_q;
    logic                       tmo_q;
    res_e                       code_q;
    bus_op_t                    op;
    logic                       irq_pend;
    logic                       wait_over;

    mbx_irq_catch u_irq (
        .clk     (clk),
        .rst     (rst),
        .irq     (irq),
        .clr     (state == ST_CMD_WR),
        .pending (irq_pend)
    );

    mbx_wait_timer #(
        .PRESCALE      (PRESCALE),
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WAIT),
        .expired (wait_over)
    );

    always_comb begin
        op = '{req: 1'b0, we: 1'b0, space: SP_MBOX, addr: '0, wdata: '0};
        case (state)
            ST_POLL:     op = '{req: 1'b1, we: 1'b0, space: SP_MBOX, addr: OFS_CMD,         wdata: '0};
            ST_CLR_PRE,
            ST_CLR_POST: op = '{req: 1'b1, we: 1'b1, space: SP_MBOX, addr: OFS_STAT,        wdata: '0};
            ST_ARG_WR:   op = '{req: 1'b1, we: 1'b1, space: SP_MBOX, addr: param_addr(idx), wdata: args_q[idx]};
            ST_CMD_WR:   op = '{req: 1'b1, we: 1'b1, space: SP_MBOX, addr: OFS_CMD,         wdata: cmd_q};
            ST_RING:     op = '{req: 1'b1, we: 1'b1, space: SP_INTC, addr: OFS_DOORBELL,    wdata: DOORBELL_VAL};
            ST_STAT_RD:  op = '{req: 1'b1, we: 1'b0, space: SP_MBOX, addr: OFS_STAT,        wdata: '0};
            ST_ARG_RD:   op = '{req: 1'b1, we: 1'b0, space: SP_MBOX, addr: param_addr(idx), wdata: '0};
            default:     op = '{req: 1'b0, we: 1'b0, space: SP_MBOX, addr: '0,              wdata: '0};
        endcase
    end

    assign bus_req   = op.req;
    assign bus_we    = op.we;
    assign bus_space = op.space;
    assign bus_addr  = op.addr;
    assign bus_wdata = op.wdata;

    assign req_ready = (state == ST_IDLE);
    assign done      = (state == ST_FIN);
    assign rsp_code  = code_q;
    assign rsp_args  = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            poll_cnt <= '0;
            idx      <= '0;
            cmd_q    <= '0;
            send_q   <= 1'b0;
            args_q   <= '0;
            rd_q     <= '0;
            stat_q   <= '0;
            tmo_q    <= 1'b0;
            code_q   <= RES_OK;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cmd_q    <= req_cmd;
                        send_q   <= req_send;
                        args_q   <= req_args;
                        rd_q     <= '0;
                        poll_cnt <= '0;
                        state    <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (bus_ack) begin
                        if (bus_rdata == '0) begin
                            state <= ST_CLR_PRE;
                        end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
                            code_q <= RES_RETRY;
                            state  <= ST_FIN;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                        end
                    end
                end
                ST_CLR_PRE: begin
                    if (bus_ack) begin
                        idx   <= '0;
                        state <= send_q ? ST_ARG_WR : ST_CMD_WR;
                    end
                end
                ST_ARG_WR: begin
                    if (bus_ack) begin
                        if (idx == LAST_ARG) state <= ST_CMD_WR;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                ST_CMD_WR: begin
                    if (bus_ack) state <= ST_RING;
                end
                ST_RING: begin
                    if (bus_ack) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (irq_pend) begin
                        tmo_q <= 1'b0;
                        state <= ST_STAT_RD;
                    end else if (wait_over) begin
                        tmo_q <= 1'b1;
                        state <= ST_STAT_RD;
                    end
                end
                ST_STAT_RD: begin
                    if (bus_ack) begin
                        if (tmo_q || status_bad(bus_rdata)) begin
                            code_q <= RES_TIMEOUT;
                            state  <= ST_FIN;
                        end else begin
                            stat_q <= bus_rdata[7:0];
                            idx    <= '0;
                            state  <= send_q ? ST_CLR_POST : ST_ARG_RD;
                        end
                    end
                end
                ST_ARG_RD: begin
                    if (bus_ack) begin
                        rd_q[idx] <= bus_rdata;
                        if (idx == LAST_ARG) state <= ST_CLR_POST;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                ST_CLR_POST: begin
                    if (bus_ack) begin
                        code_q <= map_status(stat_q);
                        state  <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DOORBELL_WORD: assert property (@(posedge clk) disable iff (rst) (bus_req && bus_we && bus_space) |-> (bus_addr == OFS_DOORBELL && bus_wdata == DOORBELL_VAL)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> (!done && req_ready)); // R10
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst) (!req_ready && !done) |=> !req_ready); // R10
    AST_TAKEN_GOES_BUSY: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready); // R10
    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (rst) (req_ready || done) |-> !bus_req); // R11

endmodule

// File: tb/test_mbox_cmd_seq.sv
module test_mbox_cmd_seq;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]   code;
        logic [127:0] args;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_cmd = '0;
    logic         req_send = 1'b0;
    logic [127:0] req_args = '0;
    logic         done;
    logic [2:0]   rsp_code;
    logic [127:0] rsp_args;
    logic         bus_req, bus_we, bus_space;
    logic [7:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic         bus_ack;
    logic [31:0]  bus_rdata;
    logic         irq;

    int n_vec = 0;
    int n_bad = 0;

    // co-processor model state
    logic [31:0]  mb_cmd, mb_stat;
    logic [31:0]  mb_par [4];
    int           busy_left = 0;
    int           fw_cnt;
    int           irq_cnt;
    logic         spur_arm = 1'b0;
    logic [31:0]  fw_status = 32'hF0;
    logic [127:0] fw_resp = '0;
    logic         fw_silent = 1'b0;
    int           fw_delay = 10;
    logic [40:0]  wr_log [$];
    exp_t         exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_cmd_seq #(
        .POLL_LIMIT    (10000),
        .PRESCALE      (4),
        .TIMEOUT_TICKS (25)
    ) i_mbox_cmd_seq (
        .clk, .rst, .req_valid, .req_ready, .req_cmd, .req_send, .req_args,
        .done, .rsp_code, .rsp_args, .bus_req, .bus_we, .bus_space, .bus_addr,
        .bus_wdata, .bus_ack, .bus_rdata, .irq
    );

    assign bus_ack = bus_req;
    assign irq     = (irq_cnt != 0);

    always_comb begin
        bus_rdata = '0;
        if (!bus_space) begin
            case (bus_addr)
                8'h00: bus_rdata = (busy_left != 0) ? 32'h0000_FFFF : mb_cmd;
                8'h04: bus_rdata = mb_stat;
                8'h18: bus_rdata = mb_par[0];
                8'h1C: bus_rdata = mb_par[1];
                8'h20: bus_rdata = mb_par[2];
                8'h24: bus_rdata = mb_par[3];
                default: bus_rdata = '0;
            endcase
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            mb_cmd  <= '0;
            mb_stat <= '0;
            for (int i = 0; i < 4; i++) mb_par[i] <= '0;
            fw_cnt  <= 0;
            irq_cnt <= 0;
        end else begin
            if (irq_cnt != 0) irq_cnt <= irq_cnt - 1;
            if (bus_req && bus_ack) begin
                if (bus_we) begin
                    wr_log.push_back({bus_space, bus_addr, bus_wdata});
                    if (!bus_space) begin
                        case (bus_addr)
                            8'h00: mb_cmd <= bus_wdata;
                            8'h04: mb_stat <= bus_wdata;
                            8'h18: mb_par[0] <= bus_wdata;
                            8'h1C: mb_par[1] <= bus_wdata;
                            8'h20: mb_par[2] <= bus_wdata;
                            8'h24: mb_par[3] <= bus_wdata;
                            default: ;
                        endcase
                    end else if (bus_addr == 8'h04 && bus_wdata[31]) begin
                        fw_cnt <= fw_delay;
                    end
                end else if (!bus_space && bus_addr == 8'h00) begin
                    if (busy_left != 0) busy_left <= busy_left - 1;
                    if (spur_arm) begin
                        spur_arm <= 1'b0;
                        irq_cnt  <= 2;
                    end
                end
            end
            if (fw_cnt != 0) begin
                fw_cnt <= fw_cnt - 1;
                if (fw_cnt == 1) begin
                    mb_cmd <= '0;
                    if (!fw_silent) begin
                        mb_stat <= fw_status;
                        for (int i = 0; i < 4; i++) mb_par[i] <= fw_resp[32*i +: 32];
                        irq_cnt <= 3;
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected done", 128'd1, 128'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R9 result code", {125'd0, rsp_code}, {125'd0, e.code});
                check("R8 returned args", rsp_args, e.args);
            end
        end
    end

    // kind: 0 full trace, 1 trace without closing clear, 2 no writes
    task automatic run_txn(input string tag, input logic [31:0] cmd, input logic send,
                           input logic [127:0] args, input int kind,
                           input logic [2:0] ecode, input logic [127:0] eargs);
        logic [40:0] ex [$];
        int n;
        wr_log.delete();
        exp_q.push_back('{code: ecode, args: eargs});
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = cmd;
        req_send  = send;
        req_args  = args;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R10 ready low while busy"}, {127'd0, req_ready}, 128'd0);
        n = 0;
        while (!done && n < 30000) begin
            @(negedge clk);
            n++;
        end
        if (kind != 2) begin
            ex.push_back({1'b0, 8'h04, 32'h0});
            if (send)
                for (int i = 0; i < 4; i++)
                    ex.push_back({1'b0, 8'(8'h18 + 4*i), args[32*i +: 32]});
            ex.push_back({1'b0, 8'h00, cmd});
            ex.push_back({1'b1, 8'h04, 32'h8000_0000});
            if (kind == 0) ex.push_back({1'b0, 8'h04, 32'h0});
        end
        check({tag, " R2 R3 R4 write count"}, 128'(wr_log.size()), 128'(ex.size()));
        for (int i = 0; i < ex.size() && i < wr_log.size(); i++)
            check($sformatf("%s R2 R3 R4 write %0d", tag, i), {87'd0, wr_log[i]}, {87'd0, ex[i]});
        @(negedge clk);
        check({tag, " R10 ready after done"}, {127'd0, req_ready}, 128'd1);
    endtask

    initial begin
        logic [127:0] a;
        logic [127:0] r;
        a = {32'hDDDD_0004, 32'hCCCC_0003, 32'hBBBB_0002, 32'hAAAA_0001};
        r = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
        fw_resp = r;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset ready", {127'd0, req_ready}, 128'd1);
        check("R11 reset done", {127'd0, done}, 128'd0);
        check("R11 reset bus_req", {127'd0, bus_req}, 128'd0);

        fw_status = 32'hF0;
        run_txn("R3 send ok", 32'h31, 1'b1, a, 0, 3'd0, '0);
        run_txn("R8 receive ok", 32'h30, 1'b0, a, 0, 3'd0, r);

        fw_status = 32'hF1; run_txn("R9 invalid",     32'h40, 1'b0, a, 0, 3'd3, r);
        fw_status = 32'hF2; run_txn("R9 unsupported", 32'h40, 1'b0, a, 0, 3'd4, r);
        fw_status = 32'hF3; run_txn("R9 no map",      32'h41, 1'b1, a, 0, 3'd5, '0);
        fw_status = 32'hF4; run_txn("R9 map set",     32'h31, 1'b1, a, 0, 3'd6, '0);
        fw_status = 32'hFF; run_txn("R9 io failure",  32'h40, 1'b0, a, 0, 3'd7, r);
        fw_status = 32'h42; run_txn("R9 other byte",  32'h40, 1'b0, a, 0, 3'd0, r);

        fw_status = 32'h100; run_txn("R7 status above range", 32'h40, 1'b0, a, 1, 3'd2, '0);
        fw_status = 32'h0;   run_txn("R7 status zero",        32'h41, 1'b1, a, 1, 3'd2, '0);

        fw_status = 32'hF0;
        fw_silent = 1'b1;
        run_txn("R6 silent coprocessor", 32'h11, 1'b0, a, 1, 3'd2, '0);

        busy_left = 3;
        spur_arm  = 1'b1;
        run_txn("R5 stale edge, no completion", 32'h11, 1'b0, a, 1, 3'd2, '0);
        fw_silent = 1'b0;
        busy_left = 3;
        spur_arm  = 1'b1;
        run_txn("R5 stale edge then completion", 32'h11, 1'b0, a, 0, 3'd0, r);

        busy_left = 9999;
        run_txn("R1 idle on last poll", 32'h18, 1'b1, a, 0, 3'd0, '0);
        busy_left = 10000;
        run_txn("R1 retry after limit", 32'h18, 1'b1, a, 2, 3'd1, '0);
        busy_left = 0;

        repeat (3) @(negedge clk);
        check("R10 all results seen", 128'(exp_q.size()), 128'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule